// File: doc/BRIEF.md
# Prioritized Programmable Interrupt Controller

This block collects a small set of interrupt inputs for one processor, ranks them by a 4-bit priority and raises a single interrupt request whenever the best waiting source beats both the current task priority and the priority of whatever is already being serviced. Each source has one configuration word that holds its mask, its routing to the critical output, its trigger sense, its polarity, its priority and its vector. Software takes an interrupt by reading the acknowledge location, which returns a vector and marks that source in service. Software ends it by writing the end-of-interrupt location. Service can nest by priority.

Sources come in three classes, fixed by parameter. External sources pick level or edge triggering through their sense bit. Internal sources are always level-triggered. Timer and inter-processor sources are always edge-triggered. A source routed as critical stays out of the whole priority path and drives a separate critical output straight from its input level.

Top module: `prio_intc`

## Requirements
- R1: The register map is: words 0..NUM_SRC-1 are the source words, NUM_SRC is the task priority (bits 3:0, reset 15), NUM_SRC+1 is acknowledge (read), NUM_SRC+2 is end-of-interrupt (write) and NUM_SRC+3 is the spurious vector (reset all ones). In a source word, bit 31 is mask, bit 30 is critical routing, bit 23 is polarity, bit 22 is sense (1 = level), bits 19:16 are priority and bits VEC_W-1:0 are the vector. All other bits read zero. Polarity reads back as written and has no other effect. A source word resets to mask set and all other fields zero.
- R2: On internal-class sources, sense reads zero and the source is always level-triggered. On timer-class sources, sense and polarity read zero and the source is always edge-triggered.
- R3: A pending level source leaves the pending set one cycle after its input falls or its mask is set.
- R4: An edge source becomes pending one cycle after a rising input edge. Further edges before acknowledge still give only one delivery, and acknowledge clears the pending bit.
- R5: irq_o is high exactly when some unmasked, pending, non-critical source that is not in service has a priority greater than the task priority and greater than the highest in-service priority. The comparison is signed, with an empty in-service set counting as -1. A task-priority write takes effect on irq_o in the cycle after the write.
- R6: An acknowledge read while irq_o is high returns the vector of the highest-priority eligible source. Ties go to the lowest index. That source moves into the in-service set.
- R7: An acknowledge read while irq_o is low returns the spurious vector and changes neither the pending set nor the in-service set.
- R8: End-of-interrupt removes the highest-priority in-service source. With nothing in service it has no effect.
- R9: A source with critical routing set drives crit_o from its input level whatever its mask is. It never raises irq_o and is never returned by acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | NUM_SRC | Interrupt source inputs, active high |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (side effect on acknowledge) |
| reg_addr_i | input | ADDR_W | Register word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, combinational from address |
| irq_o | output | 1 | Interrupt request to the processor |
| crit_o | output | 1 | Critical interrupt request |

## Verification
The bench sweeps all 256 pairs of source priority and task priority and checks the strict-greater rule. A design that used greater-or-equal, or treated the idle in-service value as unsigned, would raise irq_o at the wrong threshold. Equal-priority pending sources are raced to expose a tie broken toward the higher index. A pending source that is still being serviced is checked for suppression, which a design missing the in-service comparison would redeliver. End-of-interrupt is issued under nesting and with nothing in service, where a design that cleared the wrong entry or wrapped an empty index would lose or duplicate deliveries. Level withdrawal on deassert and on mask is checked, along with repeated edges that must collapse into one delivery, class-forced sense bits, spurious acknowledges that must leave pending state untouched, and critical sources that must bypass masking and acknowledge.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int MASK_BIT  = 31;
  localparam int ROUTE_BIT = 30;
  localparam int POL_BIT   = 23;
  localparam int SENSE_BIT = 22;
  localparam int PRIO_LSB  = 16;
  localparam int PRIO_W    = 4;

  typedef enum logic [1:0] {
    CLS_EXT = 2'd0,
    CLS_INT = 2'd1,
    CLS_TMR = 2'd2
  } src_cls_e;
endpackage

// File: rtl/intc_src.sv
module intc_src
  import intc_pkg::*;
#(
  parameter int       VEC_W = 8,
  parameter src_cls_e CLS   = CLS_EXT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lvl_i,
  input  logic              we_i,
  input  logic [31:0]       wdata_i,
  input  logic              ack_clr_i,
  output logic [31:0]       rdata_o,
  output logic              pend_o,
  output logic [PRIO_W-1:0] prio_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic              crit_o
);
  logic              mask_q, route_q, pol_q, sense_q, in_q, pend_q;
  logic [PRIO_W-1:0] prio_q;
  logic [VEC_W-1:0]  vec_q;
  logic              eff_level, rise, pend_d;

  generate
    if (CLS == CLS_INT) begin : g_int
      assign eff_level = 1'b1;
    end else if (CLS == CLS_TMR) begin : g_tmr
      assign eff_level = 1'b0;
    end else begin : g_ext
      assign eff_level = sense_q;
    end
  endgenerate

  assign rise = lvl_i & ~in_q;

  always_comb begin
    pend_d = pend_q;
    if (route_q)        pend_d = 1'b0;
    else if (eff_level) pend_d = lvl_i & ~mask_q;
    else if (rise)      pend_d = 1'b1;
    else if (ack_clr_i) pend_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q  <= 1'b1;
      route_q <= 1'b0;
      pol_q   <= 1'b0;
      sense_q <= 1'b0;
      prio_q  <= '0;
      vec_q   <= '0;
      in_q    <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      in_q   <= lvl_i;
      pend_q <= pend_d;
      if (we_i) begin
        mask_q  <= wdata_i[MASK_BIT];
        route_q <= wdata_i[ROUTE_BIT];
        pol_q   <= (CLS == CLS_TMR) ? 1'b0 : wdata_i[POL_BIT];
        sense_q <= (CLS == CLS_EXT) ? wdata_i[SENSE_BIT] : 1'b0;
        prio_q  <= wdata_i[PRIO_LSB +: PRIO_W];
        vec_q   <= wdata_i[VEC_W-1:0];
      end
    end
  end

  always_comb begin
    rdata_o                       = '0;
    rdata_o[MASK_BIT]             = mask_q;
    rdata_o[ROUTE_BIT]            = route_q;
    rdata_o[POL_BIT]              = pol_q;
    rdata_o[SENSE_BIT]            = sense_q;
    rdata_o[PRIO_LSB +: PRIO_W]   = prio_q;
    rdata_o[VEC_W-1:0]            = vec_q;
  end

  assign pend_o = pend_q & ~mask_q & ~route_q;
  assign prio_o = prio_q;
  assign vec_o  = vec_q;
  assign crit_o = route_q & lvl_i;

  p_lvl_drop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eff_level && !lvl_i) |=> !pend_q);
  p_lvl_mask_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eff_level && mask_q) |=> !pend_q);
  p_edge_latch_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!eff_level && !route_q && lvl_i && !in_q) |=> pend_q);
endmodule

// File: rtl/intc_arb.sv
module intc_arb #(
  parameter int N     = 8,
  parameter int PW    = 4,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]          req_i,
  input  logic [N-1:0][PW-1:0]  prio_i,
  output logic                  valid_o,
  output logic [IDX_W-1:0]      idx_o,
  output logic signed [PW:0]    top_o
);
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    top_o   = '1;
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && (!valid_o || $signed({1'b0, prio_i[i]}) > top_o)) begin
        valid_o = 1'b1;
        idx_o   = IDX_W'(i);
        top_o   = $signed({1'b0, prio_i[i]});
      end
    end
  end
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import intc_pkg::*;
#(
  parameter int           NUM_SRC   = 8,
  parameter int           VEC_W     = 8,
  parameter int           ADDR_W    = 4,
  parameter logic [7:0]   INT_CLASS = 8'b0011_0000,
  parameter logic [7:0]   TMR_CLASS = 8'b1100_0000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               reg_we_i,
  input  logic               reg_re_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [31:0]        reg_wdata_i,
  output logic [31:0]        reg_rdata_o,
  output logic               irq_o,
  output logic               crit_o
);
  localparam int IDX_W     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam int CTPR_ADDR = NUM_SRC;
  localparam int ACK_ADDR  = NUM_SRC + 1;
  localparam int EOI_ADDR  = NUM_SRC + 2;
  localparam int SPUR_ADDR = NUM_SRC + 3;

  logic [NUM_SRC-1:0][31:0]       src_rdata;
  logic [NUM_SRC-1:0][PRIO_W-1:0] src_prio;
  logic [NUM_SRC-1:0][VEC_W-1:0]  src_vec;
  logic [NUM_SRC-1:0]             src_pend, src_crit, ack_clr;
  logic [NUM_SRC-1:0]             isr_q, isr_d;
  logic [PRIO_W-1:0]              ctpr_q;
  logic [VEC_W-1:0]               spur_q;

  logic                           pend_valid, isr_valid;
  logic [IDX_W-1:0]               pend_idx, isr_idx;
  logic signed [PRIO_W:0]         pend_top, isr_top, ctpr_s;
  logic                           deliver, ack_rd, ack_fire, eoi_fire;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    localparam src_cls_e C = INT_CLASS[i] ? CLS_INT : (TMR_CLASS[i] ? CLS_TMR : CLS_EXT);
    intc_src #(.VEC_W(VEC_W), .CLS(C)) u_src (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .lvl_i     (src_i[i]),
      .we_i      (reg_we_i && reg_addr_i == ADDR_W'(i)),
      .wdata_i   (reg_wdata_i),
      .ack_clr_i (ack_clr[i]),
      .rdata_o   (src_rdata[i]),
      .pend_o    (src_pend[i]),
      .prio_o    (src_prio[i]),
      .vec_o     (src_vec[i]),
      .crit_o    (src_crit[i])
    );
    assign ack_clr[i] = ack_fire && pend_idx == IDX_W'(i);
  end

  intc_arb #(.N(NUM_SRC), .PW(PRIO_W)) u_pend_arb (
    .req_i   (src_pend & ~isr_q),
    .prio_i  (src_prio),
    .valid_o (pend_valid),
    .idx_o   (pend_idx),
    .top_o   (pend_top)
  );

  intc_arb #(.N(NUM_SRC), .PW(PRIO_W)) u_isr_arb (
    .req_i   (isr_q),
    .prio_i  (src_prio),
    .valid_o (isr_valid),
    .idx_o   (isr_idx),
    .top_o   (isr_top)
  );

  assign ctpr_s   = $signed({1'b0, ctpr_q});
  assign deliver  = pend_valid && (pend_top > ctpr_s) && (pend_top > isr_top);
  assign ack_rd   = reg_re_i && reg_addr_i == ADDR_W'(ACK_ADDR);
  assign ack_fire = ack_rd && deliver;
  assign eoi_fire = reg_we_i && reg_addr_i == ADDR_W'(EOI_ADDR) && isr_valid;

  always_comb begin
    isr_d = isr_q;
    if (eoi_fire) isr_d[isr_idx]  = 1'b0;
    if (ack_fire) isr_d[pend_idx] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      isr_q  <= '0;
      ctpr_q <= '1;
      spur_q <= '1;
    end else begin
      isr_q <= isr_d;
      if (reg_we_i && reg_addr_i == ADDR_W'(CTPR_ADDR)) ctpr_q <= reg_wdata_i[PRIO_W-1:0];
      if (reg_we_i && reg_addr_i == ADDR_W'(SPUR_ADDR)) spur_q <= reg_wdata_i[VEC_W-1:0];
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    for (int i = 0; i < NUM_SRC; i++)
      if (reg_addr_i == ADDR_W'(i)) reg_rdata_o = src_rdata[i];
    if (reg_addr_i == ADDR_W'(CTPR_ADDR)) reg_rdata_o[PRIO_W-1:0] = ctpr_q;
    if (reg_addr_i == ADDR_W'(ACK_ADDR))
      reg_rdata_o[VEC_W-1:0] = deliver ? src_vec[pend_idx] : spur_q;
    if (reg_addr_i == ADDR_W'(SPUR_ADDR)) reg_rdata_o[VEC_W-1:0] = spur_q;
  end

  assign irq_o  = deliver;
  assign crit_o = |src_crit;

  p_ack_isr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_rd && irq_o) |=> isr_q[$past(pend_idx)]);
  p_spur_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_rd && !irq_o && !reg_we_i) |=> $stable(isr_q));
  p_eoi_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == ADDR_W'(EOI_ADDR) && isr_q == '0 && !(ack_rd && irq_o))
      |=> isr_q == '0);
  p_crit_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_rd && irq_o) |-> !src_crit[pend_idx]);
endmodule

// File: tb/prio_intc_tb.sv
module prio_intc_tb;
  localparam int N = 8;
  localparam logic [31:0] LVL  = 32'h0040_0000;
  localparam logic [31:0] MSK  = 32'h8000_0000;
  localparam logic [31:0] RTE  = 32'h4000_0000;
  localparam logic [3:0]  A_CTPR = 4'd8, A_ACK = 4'd9, A_EOI = 4'd10, A_SPUR = 4'd11;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [N-1:0] src_i = '0;
  logic        reg_we_i = 1'b0, reg_re_i = 1'b0;
  logic [3:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        irq_o, crit_o;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;
  logic [31:0] d;

  always #5 clk_i = ~clk_i;

  prio_intc u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_i(src_i),
    .reg_we_i(reg_we_i), .reg_re_i(reg_re_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .irq_o(irq_o), .crit_o(crit_o)
  );

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk_i);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] v);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = v;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk_i);
    reg_re_i = 1'b1; reg_addr_i = a;
    #1 v = reg_rdata_o;
    @(negedge clk_i);
    reg_re_i = 1'b0;
  endtask

  task automatic pulse(input int i);
    @(negedge clk_i); src_i[i] = 1'b1;
    @(negedge clk_i); src_i[i] = 1'b0;
    tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog got=timeout exp=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    tick();
    // R1 reset state
    chk(irq_o, 0, "R1 irq reset");
    chk(crit_o, 0, "R1 crit reset");
    rd(4'd0, d); chk(d, 32'h8000_0000, "R1 src reset");
    rd(A_CTPR, d); chk(d, 32'h0000_000F, "R1 ctpr reset");
    rd(A_SPUR, d); chk(d, 32'h0000_00FF, "R1 spur reset");
    // R1 field layout, polarity stored
    wr(4'd1, 32'hFFFF_FFFF); rd(4'd1, d); chk(d, 32'hC0CF_00FF, "R1 ext readback");
    wr(4'd0, 32'h80C5_003C); rd(4'd0, d); chk(d, 32'h80C5_003C, "R1 polarity kept");
    // R2 class-forced bits
    wr(4'd4, 32'hFFFF_FFFF); rd(4'd4, d); chk(d, 32'hC08F_00FF, "R2 internal sense zero");
    wr(4'd6, 32'hFFFF_FFFF); rd(4'd6, d); chk(d, 32'hC00F_00FF, "R2 timer sense pol zero");
    wr(4'd4, MSK); wr(4'd6, MSK);

    // R5 sweep of source priority against task priority
    @(negedge clk_i); src_i[0] = 1'b1;
    for (int p = 0; p < 16; p++) begin
      wr(4'd0, LVL | (32'(p) << 16) | 32'h10);
      for (int c = 0; c < 16; c++) begin
        wr(A_CTPR, 32'(c));
        chk(irq_o, (p > c) ? 1 : 0, "R5 threshold sweep");
      end
    end

    // R3 level withdrawal
    wr(A_CTPR, 0);
    wr(4'd0, LVL | (3 << 16) | 32'h10);
    wr(4'd1, (7 << 16) | 32'h11);
    wr(4'd2, (9 << 16) | 32'h12);
    tick(); chk(irq_o, 1, "R3 level pending");
    @(negedge clk_i); src_i[0] = 1'b0; tick();
    chk(irq_o, 0, "R3 deassert withdraws");
    @(negedge clk_i); src_i[0] = 1'b1; tick();
    chk(irq_o, 1, "R3 reassert");
    wr(4'd0, MSK | LVL | (3 << 16) | 32'h10); tick();
    chk(irq_o, 0, "R3 mask withdraws");
    wr(4'd0, LVL | (3 << 16) | 32'h10); tick();
    chk(irq_o, 1, "R3 unmask");
    @(negedge clk_i); src_i[0] = 1'b0; tick();

    // R6 priority order, R5 in-service suppression
    pulse(1); pulse(2);
    chk(irq_o, 1, "R4 edge pending");
    rd(A_ACK, d); chk(d, 32'h12, "R6 higher prio first");
    chk(irq_o, 0, "R5 below in-service");
    wr(A_EOI, 0);
    rd(A_ACK, d); chk(d, 32'h11, "R6 next vector");
    wr(A_EOI, 0);
    chk(irq_o, 0, "R4 edge cleared by ack");
    // R6 tie to lowest index
    wr(4'd2, (7 << 16) | 32'h12);
    pulse(2); pulse(1);
    rd(A_ACK, d); chk(d, 32'h11, "R6 tie lowest index");
    chk(irq_o, 0, "R5 equal to in-service");
    wr(A_EOI, 0);
    rd(A_ACK, d); chk(d, 32'h12, "R6 tie second");
    wr(A_EOI, 0);

    // R4 repeated edges give one delivery
    pulse(1); pulse(1);
    rd(A_ACK, d); chk(d, 32'h11, "R4 first delivery");
    wr(A_EOI, 0);
    chk(irq_o, 0, "R4 no duplicate");
    rd(A_ACK, d); chk(d, 32'hFF, "R4 spurious after single");

    // R7 spurious leaves state
    wr(A_SPUR, 32'h5A);
    @(negedge clk_i); src_i[0] = 1'b1; tick();
    wr(A_CTPR, 15);
    chk(irq_o, 0, "R5 ctpr blocks");
    rd(A_ACK, d); chk(d, 32'h5A, "R7 spurious vector");
    wr(A_CTPR, 0);
    chk(irq_o, 1, "R7 pending kept");
    rd(A_ACK, d); chk(d, 32'h10, "R7 ack after spurious");

    // R8 nesting and end-of-interrupt
    chk(irq_o, 0, "R5 level in service");
    pulse(1);
    chk(irq_o, 1, "R5 preempt");
    rd(A_ACK, d); chk(d, 32'h11, "R8 nested ack");
    wr(A_EOI, 0);
    chk(irq_o, 0, "R8 eoi removes top only");
    wr(A_EOI, 0);
    chk(irq_o, 1, "R8 second eoi frees level");
    wr(A_EOI, 0);
    chk(irq_o, 1, "R8 idle eoi ignored");
    rd(A_ACK, d); chk(d, 32'h10, "R8 state intact");
    wr(A_EOI, 0);
    @(negedge clk_i); src_i[0] = 1'b0; tick();
    chk(irq_o, 0, "R8 quiet");

    // R9 critical routing
    wr(4'd3, MSK | RTE | (12 << 16) | 32'h13);
    @(negedge clk_i); src_i[3] = 1'b1;
    #1 chk(crit_o, 1, "R9 crit follows input masked");
    tick(); chk(irq_o, 0, "R9 no irq");
    rd(A_ACK, d); chk(d, 32'h5A, "R9 not acknowledged");
    @(negedge clk_i); src_i[3] = 1'b0;
    #1 chk(crit_o, 0, "R9 crit drops");
    wr(4'd3, RTE | LVL | (12 << 16) | 32'h13);
    @(negedge clk_i); src_i[3] = 1'b1;
    #1 chk(crit_o, 1, "R9 crit unmasked");
    tick(); chk(irq_o, 0, "R9 bypass priority");
    @(negedge clk_i); src_i[3] = 1'b0; tick();

    // R2 timer forced edge, internal forced level
    wr(4'd6, LVL | (9 << 16) | 32'h16);
    @(negedge clk_i); src_i[6] = 1'b1; tick();
    chk(irq_o, 1, "R2 timer edge");
    rd(A_ACK, d); chk(d, 32'h16, "R2 timer vector");
    wr(A_EOI, 0); tick();
    chk(irq_o, 0, "R2 timer not level");
    @(negedge clk_i); src_i[6] = 1'b0;
    wr(4'd4, (9 << 16) | 32'h14);
    @(negedge clk_i); src_i[4] = 1'b1; tick();
    rd(A_ACK, d); chk(d, 32'h14, "R2 internal vector");
    wr(A_EOI, 0); tick();
    chk(irq_o, 1, "R2 internal stays level");
    @(negedge clk_i); src_i[4] = 1'b0; tick();
    chk(irq_o, 0, "R2 internal withdraws");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule